// File: doc/BRIEF.md
# Change-of-State Digital Input Port

This block samples 48 digital input lines and makes them readable through a small window of eight 8-bit registers. The lines are split into six byte-groups of eight. The groups sit in two banks of three consecutive offsets, with an unused offset between the banks. The last offset is a combined control and status register. Every line is an input; the block drives no pins.

Software sets a 6-bit mask that arms change-of-state detection for each byte-group. Any rising or falling transition on a line of an armed group latches that group's status bit. The latched bits raise a level interrupt and clear a pending flag, which is active low. Reading the status register returns the latched group bits and the pending flag, and acknowledges them: the latched state is cleared in the same clock edge. A change that is latched in the same edge as the acknowledge is kept for the next read.

Top module: `cos_input_port`

## Requirements
- R1: Input line 8*g+k appears at bit k of the byte register of group g. Groups 0, 1 and 2 are at offsets 0, 1 and 2. Groups 3, 4 and 5 are at offsets 4, 5 and 6. The value is the line after a two-flop synchroniser, so a change on `din` is readable after the second rising clock edge.
- R2: A read of offset 3 returns 0x00.
- R3: A write to offset 7 loads `wdata[5:0]` into the group arm mask; `wdata[7:6]` are dropped. After reset the mask is 0.
- R4: A rising or a falling transition on any line of an armed group g sets status bit g. The bit is visible at the third rising edge after the `din` change.
- R5: A transition on a line of a group whose arm bit is 0 sets no status bit, and it leaves no latent status that shows once the group is armed later.
- R6: Status bits are sticky. They stay set until a read of offset 7, whatever further input activity takes place.
- R7: A read of offset 7 (`rd_en` high with `addr` = 7 at a rising edge) clears every status bit at that edge. A status bit that is set at the same edge is kept and is reported by the next read.
- R8: A read of offset 7 returns the status bits in bits 5..0. Bit 6 is 0 exactly when some armed group has its status bit set, and 1 otherwise. Bit 7 is always 0.
- R9: `irq` is a level that is high while some armed group has its status bit set. Writing 0 to offset 7 drops it at the next edge. The status bits stay readable until the next read of offset 7.
- R10: Writes to offsets 0 to 6 have no effect: the arm mask, the status and the input readback are unchanged.
- R11: After reset, the status is 0, `irq` is low and a read of offset 7 returns 0x40.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| din | input | 48 | Asynchronous digital input lines |
| addr | input | 3 | Register offset |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach from the ports is a status bit being set in the same clock edge that a status read clears the register. To hit it, the stimulus toggles one line on a falling edge, waits exactly two rising edges, and then issues the status read, so that the acknowledge lands on the edge where the new change is latched. The bench checks that this read reports nothing and that the following read reports the group. The other cases are covered by a sweep that toggles every one of the 48 lines under two arm masks, in both directions. After each toggle the bench compares all eight offsets, the interrupt and the clear-on-read against a model that it computes arithmetically.

// File: rtl/cos_pkg.sv
package cos_pkg;
    localparam int NUM_GROUPS  = 6;
    localparam int GROUP_W     = 8;
    localparam int BANK_GROUPS = 3;
    localparam int BANK_SLOTS  = 4;
    localparam int ADDR_W      = 3;
    localparam int DATA_W      = 8;
    localparam int STAT_ADDR   = 7;
    localparam int PEND_BIT    = 6;

    // Register offset of a byte-group: banks of BANK_SLOTS offsets, BANK_GROUPS used.
    function automatic int grp_offset(input int g);
        return (g / BANK_GROUPS) * BANK_SLOTS + (g % BANK_GROUPS);
    endfunction
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] sync,
    output logic [W-1:0] chg
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = raw;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync = st_q.s2;
    assign chg  = st_q.s2 ^ st_q.prev;
endmodule

// File: rtl/cos_status.sv
module cos_status #(
    parameter int G = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [G-1:0] grp_chg,
    input  logic         ack,
    input  logic         arm_we,
    input  logic [G-1:0] arm_wdata,
    output logic [G-1:0] stat_q,
    output logic [G-1:0] arm_q,
    output logic         pending
);
    typedef struct packed {
        logic [G-1:0] arm;
        logic [G-1:0] stat;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (arm_we) st_d.arm = arm_wdata;
        // clear on acknowledge, but a change latched at the same edge survives
        st_d.stat = (ack ? '0 : st_q.stat) | (grp_chg & st_q.arm);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_q  = st_q.stat;
    assign arm_q   = st_q.arm;
    assign pending = |(st_q.stat & st_q.arm);
endmodule

// File: rtl/cos_rd_mux.sv
module cos_rd_mux
    import cos_pkg::*;
#(
    parameter int G = NUM_GROUPS,
    parameter int W = GROUP_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [G*W-1:0]    sync,
    input  logic [G-1:0]      stat,
    input  logic              pending,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(STAT_ADDR)) begin
            rdata[G-1:0]    = stat;
            rdata[PEND_BIT] = ~pending;
        end else begin
            for (int g = 0; g < G; g++) begin
                if (addr == ADDR_W'(grp_offset(g))) rdata[W-1:0] = sync[g*W +: W];
            end
        end
    end
endmodule

// File: rtl/cos_input_port.sv
module cos_input_port
    import cos_pkg::*;
#(
    parameter int G = NUM_GROUPS,
    parameter int W = GROUP_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [G*W-1:0]      din,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                rd_en,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic                irq
);
    localparam int LINES = G * W;

    logic [LINES-1:0] sync;
    logic [LINES-1:0] line_chg;
    logic [G-1:0]     grp_chg;
    logic [G-1:0]     stat_q;
    logic [G-1:0]     arm_q;
    logic             pending;
    logic             ack;
    logic             arm_we;
    logic             unused_wdata;

    assign ack          = rd_en && (addr == ADDR_W'(STAT_ADDR));
    assign arm_we       = wr_en && (addr == ADDR_W'(STAT_ADDR));
    assign unused_wdata = &{1'b0, wdata[DATA_W-1:G]};

    for (genvar g = 0; g < G; g++) begin : g_grp
        cos_sync #(.W(W)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (din[g*W +: W]),
            .sync (sync[g*W +: W]),
            .chg  (line_chg[g*W +: W])
        );
        assign grp_chg[g] = |line_chg[g*W +: W];
    end

    cos_status #(.G(G)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .grp_chg  (grp_chg),
        .ack      (ack),
        .arm_we   (arm_we),
        .arm_wdata(wdata[G-1:0]),
        .stat_q   (stat_q),
        .arm_q    (arm_q),
        .pending  (pending)
    );

    cos_rd_mux #(.G(G), .W(W)) u_mux (
        .addr   (addr),
        .sync   (sync),
        .stat   (stat_q),
        .pending(pending),
        .rdata  (rdata)
    );

    assign irq = pending;
endmodule

// File: rtl/cos_input_port_chk.sv
module cos_input_port_chk
    import cos_pkg::*;
#(
    parameter int G = NUM_GROUPS
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   addr,
    input logic                rd_en,
    input logic                wr_en,
    input logic [DATA_W-1:0]   wdata,
    input logic [DATA_W-1:0]   rdata,
    input logic                irq,
    input logic [G-1:0]        stat_q,
    input logic [G-1:0]        arm_q,
    input logic [G-1:0]        grp_chg
);
    logic rd7;
    logic wr7;
    assign rd7 = rd_en && (addr == ADDR_W'(STAT_ADDR));
    assign wr7 = wr_en && (addr == ADDR_W'(STAT_ADDR));

    AST_OFF3_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(3)) |-> (rdata == '0)); // R2

    AST_ARM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr7 |=> (arm_q == $past(wdata[G-1:0]))); // R3

    AST_ARM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr7 |=> $stable(arm_q)); // R10

    AST_NO_SET_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(arm_q)) == '0)); // R5

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !rd7 |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R6

    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd7 && grp_chg == '0) |=> (stat_q == '0)); // R7

    AST_PEND_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(STAT_ADDR)) |-> (rdata[PEND_BIT] == !irq && rdata[DATA_W-1] == 1'b0)); // R8

    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr7 && wdata[G-1:0] == '0) |=> !irq); // R9
endmodule

bind cos_input_port cos_input_port_chk #(.G(G)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (addr),
    .rd_en  (rd_en),
    .wr_en  (wr_en),
    .wdata  (wdata),
    .rdata  (rdata),
    .irq    (irq),
    .stat_q (stat_q),
    .arm_q  (arm_q),
    .grp_chg(grp_chg)
);

// File: tb/tb_cos_input_port.sv
module tb_cos_input_port;
    localparam int CLK_PERIOD = 10;
    localparam int NG = 6;
    localparam int NL = 48;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] din = '0;
    logic [2:0]    addr = '0;
    logic          rd_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;

    cos_input_port dut (
        .clk(clk), .rst_n(rst_n), .din(din), .addr(addr), .rd_en(rd_en),
        .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(posedge clk);
        #1 rd_en = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    // expected content of an offset for the current line values (R1, R2)
    function automatic logic [7:0] exp_byte(input int a, input logic [NL-1:0] v);
        int g;
        if (a == 3) return 8'h00;
        g = (a / 4) * 3 + (a % 4);
        return v[g*8 +: 8];
    endfunction

    function automatic logic [7:0] exp_stat(input logic [5:0] st, input logic [5:0] arm);
        return {1'b0, ((st & arm) != 0) ? 1'b0 : 1'b1, st};
    endfunction

    task automatic check_inputs(input string req);
        logic [7:0] v;
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v);
            chk(req, v, exp_byte(a, din));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [5:0] arm;
        int g;

        step(3);
        rst_n = 1'b1;
        step(1);

        // R11 reset state
        chk("R11 irq", {7'b0, irq}, 8'h00);
        rd(3'd7, v); chk("R11 status", v, 8'h40);
        check_inputs("R11 inputs");

        // R1 R4 R5 R7 R8 R9: sweep every line under two arm masks, both directions
        for (int pass = 0; pass < 4; pass++) begin
            arm = (pass % 2 == 0) ? 6'h3F : 6'h15;
            wr(3'd7, {2'b11, arm});   // R3 upper bits dropped
            for (int ln = 0; ln < NL; ln++) begin
                g = ln / 8;
                @(negedge clk) din[ln] = ~din[ln];
                step(4);
                check_inputs("R1 readback");
                chk("R9 irq level", {7'b0, irq}, {7'b0, arm[g]});
                rd(3'd7, v);
                chk("R4 R5 R8 status", v, exp_stat(arm[g] ? 6'(1 << g) : 6'h00, arm));
                step(1);
                chk("R7 irq after read", {7'b0, irq}, 8'h00);
                rd(3'd7, v); chk("R7 cleared", v, 8'h40);
            end
        end

        // R5 no latent status after arming
        wr(3'd7, 8'h00);
        @(negedge clk) din[9] = ~din[9];
        step(5);
        chk("R5 irq disarmed", {7'b0, irq}, 8'h00);
        wr(3'd7, 8'h3F);
        step(2);
        chk("R5 no latent irq", {7'b0, irq}, 8'h00);
        rd(3'd7, v); chk("R5 no latent status", v, 8'h40);

        // R7 change latched at the same edge as the acknowledge
        @(negedge clk) din[17] = ~din[17];
        @(negedge clk);
        rd(3'd7, v); chk("R7 read at set edge", v, 8'h40);
        step(1);
        chk("R7 kept irq", {7'b0, irq}, 8'h01);
        rd(3'd7, v); chk("R7 kept status", v, 8'h04);

        // R6 sticky across further activity
        @(negedge clk) din[40] = ~din[40];
        step(6);
        @(negedge clk) din[41] = ~din[41];
        @(negedge clk) din[2] = ~din[2];
        step(10);
        chk("R6 irq sticky", {7'b0, irq}, 8'h01);
        rd(3'd7, v); chk("R6 status", v, 8'h21);

        // R9 writing 0 drops irq, status stays readable until read
        @(negedge clk) din[30] = ~din[30];
        step(5);
        chk("R9 irq armed", {7'b0, irq}, 8'h01);
        wr(3'd7, 8'h00);
        step(1);
        chk("R9 irq after disarm", {7'b0, irq}, 8'h00);
        rd(3'd7, v); chk("R9 status kept", v, 8'h48);
        rd(3'd7, v); chk("R9 stale cleared", v, 8'h40);

        // R10 writes to offsets 0..6 are ignored
        wr(3'd7, 8'h20);
        for (int a = 0; a < 7; a++) wr(3'(a), 8'hFF);
        for (int a = 0; a < 7; a++) wr(3'(a), 8'h00);
        check_inputs("R10 inputs unchanged");
        @(negedge clk) din[0] = ~din[0];
        step(5);
        chk("R10 group0 still disarmed", {7'b0, irq}, 8'h00);
        @(negedge clk) din[47] = ~din[47];
        step(5);
        chk("R10 group5 still armed", {7'b0, irq}, 8'h01);
        rd(3'd7, v); chk("R10 status", v, 8'h20);

        // R2 offset 3 with all lines high
        @(negedge clk) din = '1;
        step(4);
        rd(3'd3, v); chk("R2 offset3", v, 8'h00);
        check_inputs("R1 all high");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule